// File: doc/BRIEF.md
# Predecoded Byte Write-Strobe Decoder

This block sits in front of a flip-flop storage array of 256 words by 32 bits. It turns an 8-bit write address, a chip enable and four byte-lane write enables into one strobe per stored byte. Each strobe tells one byte of flip-flops to load its 8 bits of write data instead of keeping its current value. The address is decoded in three levels of two-input ANDs. Two-bit fields are predecoded first. The predecodes are then combined into two 16-line nibble groups, and the nibble groups are combined into 256 word lines. Each word line is finally ANDed with chip enable and with one lane enable.

The write decode works on the live address in the same cycle. The block also keeps the registered read address that the read multiplexer needs. That register loads the address on an enabled cycle and keeps its value on any other cycle. Word lines and strobes are brought out as flat vectors. Strobe index `word*4 + lane` belongs to byte lane `lane` (bits `8*lane+7 : 8*lane`) of word `word`.

Top module: `wr_addr_decoder`

## Requirements
- R1: For every address value exactly one bit of `word_line` is 1, and it is bit number `addr`.
- R2: Strobe bit `w*4+b` is 1 exactly when `w` equals `addr`, `ce` is 1 and `we[b]` is 1. Lane b covers data bits 8b+7 down to 8b.
- R3: While `ce` is 0, every strobe bit is 0, whatever `we` and `addr` are.
- R4: While `we` is all zeros, every strobe bit is 0, even with `ce` at 1.
- R5: No strobe belonging to a word other than the addressed one is ever 1. The number of active strobes equals the number of enabled lanes when `ce` is 1.
- R6: Word lines and strobes follow `addr`, `ce` and `we` in the same cycle, with no register on the way. They do not use the registered read address.
- R7: On a rising clock edge with `rst` at 0 and `ce` at 1, `raddr` takes the value of `addr`.
- R8: On a rising clock edge with `rst` at 0 and `ce` at 0, `raddr` keeps its previous value.
- R9: On a rising clock edge with `rst` at 1, `raddr` becomes 0, whatever `ce` is.
- R10: Word lines depend only on `addr`. They stay decoded while `ce` or `we` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high, clears the read-address register |
| ce | input | 1 | Chip enable, active high |
| we | input | 4 | Write enable for each byte lane, active high |
| addr | input | 8 | Word address, used for the write decode and captured for reads |
| word_line | output | 256 | Decoded one-hot word select |
| strobe | output | 1024 | Byte load strobes, index word*4 + lane |
| raddr | output | 8 | Registered read address |

## Verification
A complete sweep of all 256 addresses with every lane enabled tests each path through the predecode and nibble levels. A wrong pairing of address bits shows up as a misplaced word line. Single-lane and empty lane masks with `ce` high separate the lane gating from the word gating, and vectors with `ce` low show that chip enable masks every strobe while the word lines stay decoded. Random vectors mix these cases. Runs of `ce` low between loads show whether the read-address register holds or reloads, and resets issued with `ce` high show that reset wins over a load.

// File: rtl/wdec_pkg.sv
`timescale 1ns/1ps
package wdec_pkg;
    // Shape of the decode tree: four 2-bit fields, two nibble groups.
    localparam int ADDR_W     = 8;
    localparam int FIELD_W    = 2;
    localparam int FIELDS     = ADDR_W / FIELD_W;
    localparam int FIELD_SEL  = 1 << FIELD_W;
    localparam int NIB_GROUPS = FIELDS / 2;
    localparam int NIB_SEL    = FIELD_SEL * FIELD_SEL;
    localparam int WORDS      = 1 << ADDR_W;

    typedef logic [ADDR_W-1:0] addr_t;

    typedef struct packed {
        addr_t raddr;
    } rd_state_t;
endpackage

// File: rtl/wdec_field_predec.sv
`timescale 1ns/1ps
// First level: one 2-bit address field to four one-hot lines,
// each line an AND2 of true or inverted field bits.
module wdec_field_predec (
    input  logic [1:0] fld,
    output logic [3:0] sel
);
    logic [1:0] fld_n;
    assign fld_n = ~fld;

    for (genvar k = 0; k < 4; k++) begin : g_line
        localparam logic [1:0] K = 2'(k);
        logic hi_term;
        logic lo_term;
        assign hi_term = K[1] ? fld[1] : fld_n[1];
        assign lo_term = K[0] ? fld[0] : fld_n[0];
        assign sel[k]  = hi_term & lo_term;
    end
endmodule

// File: rtl/wdec_and_cross.sv
`timescale 1ns/1ps
// Cross product of two one-hot line sets with AND2 gates.
// Output line h*LO_N + l is lo[l] AND hi[h].
module wdec_and_cross #(
    parameter int LO_N = 4,
    parameter int HI_N = 4,
    localparam int OUT_N = LO_N * HI_N
) (
    input  logic [LO_N-1:0]  lo,
    input  logic [HI_N-1:0]  hi,
    output logic [OUT_N-1:0] out
);
    for (genvar h = 0; h < HI_N; h++) begin : g_hi
        for (genvar l = 0; l < LO_N; l++) begin : g_lo
            assign out[h*LO_N + l] = lo[l] & hi[h];
        end
    end
endmodule

// File: rtl/wdec_strobe_gate.sv
`timescale 1ns/1ps
// Last level: each word line gated with chip enable and one lane enable.
module wdec_strobe_gate #(
    parameter int WORDS     = 256,
    parameter int NUM_BYTES = 4,
    localparam int STB_N    = WORDS * NUM_BYTES
) (
    input  logic [WORDS-1:0]     word_line,
    input  logic                 ce,
    input  logic [NUM_BYTES-1:0] we,
    output logic [STB_N-1:0]     strobe
);
    for (genvar w = 0; w < WORDS; w++) begin : g_word
        for (genvar b = 0; b < NUM_BYTES; b++) begin : g_lane
            assign strobe[w*NUM_BYTES + b] = word_line[w] & ce & we[b];
        end
    end
endmodule

// File: rtl/wdec_raddr_reg.sv
`timescale 1ns/1ps
// Read-address register: loads on enable, recirculates otherwise.
module wdec_raddr_reg
    import wdec_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  ce,
    input  addr_t addr,
    output addr_t raddr
);
    rd_state_t st_d;
    rd_state_t st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.raddr = '0;
        end else if (ce) begin
            st_d.raddr = addr;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign raddr = st_q.raddr;
endmodule

// File: rtl/wr_addr_decoder.sv
`timescale 1ns/1ps
module wr_addr_decoder
    import wdec_pkg::*;
#(
    parameter int NUM_BYTES = 4,
    localparam int STB_N    = WORDS * NUM_BYTES
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ce,
    input  logic [NUM_BYTES-1:0] we,
    input  logic [ADDR_W-1:0]    addr,
    output logic [WORDS-1:0]     word_line,
    output logic [STB_N-1:0]     strobe,
    output logic [ADDR_W-1:0]    raddr
);
    logic [FIELD_SEL-1:0] fld_sel [FIELDS];
    logic [NIB_SEL-1:0]   nib_sel [NIB_GROUPS];

    // Level 1: field predecode.
    for (genvar f = 0; f < FIELDS; f++) begin : g_field
        wdec_field_predec u_pre (
            .fld (addr[f*FIELD_W +: FIELD_W]),
            .sel (fld_sel[f])
        );
    end

    // Level 2: lower and upper field of each nibble.
    for (genvar g = 0; g < NIB_GROUPS; g++) begin : g_nib
        wdec_and_cross #(.LO_N(FIELD_SEL), .HI_N(FIELD_SEL)) u_nib (
            .lo  (fld_sel[2*g]),
            .hi  (fld_sel[2*g + 1]),
            .out (nib_sel[g])
        );
    end

    // Level 3: low nibble against high nibble.
    wdec_and_cross #(.LO_N(NIB_SEL), .HI_N(NIB_SEL)) u_word (
        .lo  (nib_sel[0]),
        .hi  (nib_sel[1]),
        .out (word_line)
    );

    wdec_strobe_gate #(.WORDS(WORDS), .NUM_BYTES(NUM_BYTES)) u_stb (
        .word_line (word_line),
        .ce        (ce),
        .we        (we),
        .strobe    (strobe)
    );

    wdec_raddr_reg u_rreg (
        .clk   (clk),
        .rst   (rst),
        .ce    (ce),
        .addr  (addr),
        .raddr (raddr)
    );
endmodule

// File: rtl/wdec_checker.sv
`timescale 1ns/1ps
module wdec_checker
    import wdec_pkg::*;
#(
    parameter int NUM_BYTES = 4,
    localparam int STB_N    = WORDS * NUM_BYTES
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 ce,
    input logic [NUM_BYTES-1:0] we,
    input logic [ADDR_W-1:0]    addr,
    input logic [WORDS-1:0]     word_line,
    input logic [STB_N-1:0]     strobe,
    input logic [ADDR_W-1:0]    raddr
);
    a_r1_one_word: assert property (@(posedge clk) disable iff (rst)
        $countones(word_line) == 1 && word_line[addr]);

    for (genvar b = 0; b < NUM_BYTES; b++) begin : g_lane_chk
        a_r2_lane_strobe: assert property (@(posedge clk) disable iff (rst)
            strobe[int'(addr)*NUM_BYTES + b] == (ce && we[b]));
    end

    a_r3_ce_low_quiet: assert property (@(posedge clk) disable iff (rst)
        !ce |-> strobe == '0);

    a_r4_no_lane_quiet: assert property (@(posedge clk) disable iff (rst)
        we == '0 |-> strobe == '0);

    a_r5_only_addressed: assert property (@(posedge clk) disable iff (rst)
        $countones(strobe) == (ce ? $countones(we) : 0));

    a_r7_load: assert property (@(posedge clk) disable iff (rst)
        ce |=> raddr == $past(addr));

    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        !ce |=> $stable(raddr));

    a_r9_reset: assert property (@(posedge clk)
        rst |=> raddr == '0);
endmodule

bind wr_addr_decoder wdec_checker #(.NUM_BYTES(NUM_BYTES)) u_chk (.*);

// File: tb/sim_wr_addr_decoder.sv
`timescale 1ns/1ps
module sim_wr_addr_decoder;
    localparam int NB    = 4;
    localparam int NW    = 256;
    localparam int NS    = NW * NB;

    logic          clk = 1'b0;
    logic          rst;
    logic          ce;
    logic [NB-1:0] we;
    logic [7:0]    addr;
    logic [NW-1:0] word_line;
    logic [NS-1:0] strobe;
    logic [7:0]    raddr;

    int n_chk  = 0;
    int n_fail = 0;
    logic [7:0] exp_raddr;

    always #2 clk = ~clk;

    wr_addr_decoder #(.NUM_BYTES(NB)) u0 (
        .clk(clk), .rst(rst), .ce(ce), .we(we), .addr(addr),
        .word_line(word_line), .strobe(strobe), .raddr(raddr)
    );

    function automatic logic [NW-1:0] ref_word(input logic [7:0] a);
        logic [NW-1:0] v = '0;
        v[a] = 1'b1;
        return v;
    endfunction

    function automatic logic [NS-1:0] ref_strobe(input logic [7:0] a,
                                                 input logic c,
                                                 input logic [NB-1:0] w);
        logic [NS-1:0] v = '0;
        for (int b = 0; b < NB; b++)
            if (c && w[b]) v[int'(a)*NB + b] = 1'b1;
        return v;
    endfunction

    task automatic check_bits(input string tag, input logic [NS-1:0] act,
                              input logic [NS-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Apply one vector: combinational check mid-cycle, register check after the edge.
    task automatic apply(input logic r, input logic c, input logic [NB-1:0] w,
                         input logic [7:0] a);
        string wtag, stag, rtag;
        rst = r; ce = c; we = w; addr = a;
        #1;
        if (!r) begin
            wtag = c ? "R1 R6" : "R10";
            stag = !c ? "R3" : (w == '0) ? "R4" : "R2 R5";
            check_bits(wtag, NS'(word_line), NS'(ref_word(a)));
            check_bits(stag, strobe, ref_strobe(a, c, w));
        end
        @(posedge clk);
        exp_raddr = r ? 8'h00 : (c ? a : exp_raddr);
        rtag = r ? "R9" : (c ? "R7" : "R8");
        #1;
        check_bits(rtag, NS'(raddr), NS'(exp_raddr));
    endtask

    initial begin
        #400000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        exp_raddr = 8'h00;
        rst = 1'b1; ce = 1'b0; we = '0; addr = '0;
        @(posedge clk); #1;
        // R9: reset wins over an enabled load
        apply(1'b1, 1'b1, 4'hF, 8'hA5);
        // R1 R2: full address sweep, all lanes
        for (int a = 0; a < NW; a++) apply(1'b0, 1'b1, 4'hF, 8'(a));
        // R2: single lanes at both ends of the address range
        for (int b = 0; b < NB; b++) begin
            apply(1'b0, 1'b1, 4'(1 << b), 8'h00);
            apply(1'b0, 1'b1, 4'(1 << b), 8'hFF);
        end
        // R4: no lanes with chip enable
        apply(1'b0, 1'b1, 4'h0, 8'h3C);
        // R3 R8 R10: chip enable low, address changes, register holds
        apply(1'b0, 1'b0, 4'hF, 8'hC3);
        apply(1'b0, 1'b0, 4'h5, 8'h01);
        apply(1'b0, 1'b1, 4'hA, 8'h80);
        apply(1'b0, 1'b0, 4'hA, 8'h7F);
        // R9 again after loads
        apply(1'b1, 1'b1, 4'hF, 8'h55);
        apply(1'b0, 1'b0, 4'h0, 8'h99);
        // random mix
        for (int i = 0; i < 800; i++) begin
            logic r = ($urandom % 40) == 0;
            logic c = ($urandom % 4) != 0;
            apply(r, c, 4'($urandom), 8'($urandom));
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule